// File: doc/BRIEF.md
# Sign-Aware Seven-Segment Display Decoder

This block sits behind a three-digit measurement converter that puts one 4-bit digit code at a time on a shared bus. It also drives one active-low strobe for each digit position. On every clock edge where a digit's strobe is low, the block captures the bus code into that digit's slot. Each slot is then rendered as an active-high seven-segment pattern for a common-cathode display.

A plain BCD-to-segment decoder blanks every code above nine. This decoder does more than that:

- Code 1010 in the most significant slot is drawn as a minus sign, so readings from -1 to -99 display correctly.
- When all three slots hold 1010, the reading is a negative overrange. The display then shows a minus sign in the leading digit and blanks the other two.
- When all three slots hold 1011, the reading is a positive overrange. The display then lights only segment b of the leading digit and blanks everything else.

A decimal-point select input chooses which of two decimal points is lit. The strobes, code bus and select are synchronous to the block clock.

Top module: `sign_seg7_decoder`

## Requirements
- R1: While synchronous active-low reset is applied, at the first rising edge every segment output and both decimal-point enables become 0, and all slots hold a blank code.
- R2: At a rising edge where strobe bit i is low, slot i captures `bcd_code` (bit 2 = most significant digit, bit 1 = next, bit 0 = least). The slot's segment output shows the new pattern immediately after that edge.
- R3: Codes 0 to 9 render with segment a at bit 0 through segment g at bit 6, active-high: 0=3F, 1=06, 2=5B, 3=4F, 4=66, 5=6D, 6=7D, 7=07, 8=7F, 9=6F (hex).
- R4: While a slot's strobe is high, its segment output is unchanged whatever `bcd_code` does.
- R5: Code 1010 in the most significant slot renders as a minus sign (segment g only, 40 hex). In the other two slots it renders blank, unless R8 applies.
- R6: Codes 1011 to 1111 render blank (00) in any slot, unless R8 applies.
- R7: When all three slots hold 1010, the most significant digit shows 40 and the other two show 00.
- R8: When all three slots hold 1011, the most significant digit shows 02 (segment b only) and the other two show 00.
- R9: `dp_en` is registered from `dp_sel`. One edge after `dp_sel`=0 it is 01 (point after the most significant digit). One edge after `dp_sel`=1 it is 10 (point after the next digit).
- R10: Strobes act independently. Several strobes low at one edge load the same code into every selected slot.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock; all inputs are sampled on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| bcd_code | input | 4 | Shared digit code bus |
| dig_strobe_n | input | 3 | Active-low slot strobes: bit 2 most, bit 1 next, bit 0 least significant |
| dp_sel | input | 1 | Decimal-point select: 0 after most significant digit, 1 after next digit |
| seg_msd | output | 7 | Segments a..g (bit 0..6) of the most significant digit |
| seg_nsd | output | 7 | Segments a..g of the next significant digit |
| seg_lsd | output | 7 | Segments a..g of the least significant digit |
| dp_en | output | 2 | Decimal-point enables, one-hot after reset |

## Verification
Each segment result is due directly after the single rising edge that sees its strobe low, because only the slot register lies between the input and the combinational glyph logic. The overrange override is due after the edge that completes the third matching slot. The decimal-point enables are also due one edge after the select changes. The bench drives every input on the falling edge and samples outputs on the next falling edge, so each check lands half a period after the edge that should have produced it. Hold checks repeat that sample over several edges with all strobes high.

// File: rtl/sevseg_pkg.sv
// Package: shared widths, special code values and the decimal glyph table
// for the sign-aware seven-segment decoder. Segment bit 0 is segment a,
// bit 6 is segment g, active-high.
package sevseg_pkg;
    localparam int CODE_W  = 4;
    localparam int SEG_W   = 7;
    localparam int NUM_DIG = 3;
    localparam int DP_W    = 2;

    typedef logic [SEG_W-1:0]  seg_t;
    typedef logic [CODE_W-1:0] code_t;

    localparam code_t CODE_NEG   = 4'hA;
    localparam code_t CODE_POS   = 4'hB;
    localparam code_t CODE_BLANK = 4'hF;

    localparam seg_t SEG_OFF   = 7'h00;
    localparam seg_t SEG_MINUS = 7'h40;
    localparam seg_t SEG_ONLYB = 7'h02;

    // Decimal glyph for codes 0..9; anything else is blank.
    function automatic seg_t decimal_glyph(input code_t c);
        case (c)
            4'd0:    decimal_glyph = 7'h3F;
            4'd1:    decimal_glyph = 7'h06;
            4'd2:    decimal_glyph = 7'h5B;
            4'd3:    decimal_glyph = 7'h4F;
            4'd4:    decimal_glyph = 7'h66;
            4'd5:    decimal_glyph = 7'h6D;
            4'd6:    decimal_glyph = 7'h7D;
            4'd7:    decimal_glyph = 7'h07;
            4'd8:    decimal_glyph = 7'h7F;
            4'd9:    decimal_glyph = 7'h6F;
            default: decimal_glyph = SEG_OFF;
        endcase
    endfunction
endpackage

// File: rtl/seg_slot_latch.sv
// Module: one digit slot. Captures the shared code bus on a rising edge
// where its active-low strobe is low, holds it otherwise.
// Assumes the strobe is synchronous to clk. Reset loads a blank code.
module seg_slot_latch #(
    parameter int                  W        = 4,
    parameter logic [W-1:0]        RST_CODE = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         strobe_n,
    input  logic [W-1:0] code_in,
    output logic [W-1:0] code_q
);
    // Slot register: load on strobe, blank on reset.
    always_ff @(posedge clk) begin
        if (!rst_n)         code_q <= RST_CODE;
        else if (!strobe_n) code_q <= code_in;
    end

    // R2: a low strobe captures the bus code at that edge.
    a_r2_capture: assert property (@(posedge clk) disable iff (!rst_n)
        !strobe_n |=> code_q == $past(code_in));

    // R4: a high strobe leaves the slot untouched.
    a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
        strobe_n |=> $stable(code_q));
endmodule

// File: rtl/seg_range_detect.sv
// Module: overrange detection. A full scan whose three slots all hold the
// negative-marker code flags negative overrange; all positive-marker
// codes flag positive overrange. Purely combinational.
module seg_range_detect
    import sevseg_pkg::*;
#(
    parameter int N = NUM_DIG
) (
    input  code_t slot_code [N],
    output logic  over_neg,
    output logic  over_pos
);
    // Reduce per-slot comparisons to the two overrange flags.
    always_comb begin
        over_neg = 1'b1;
        over_pos = 1'b1;
        for (int i = 0; i < N; i++) begin
            over_neg &= (slot_code[i] == CODE_NEG);
            over_pos &= (slot_code[i] == CODE_POS);
        end
    end
endmodule

// File: rtl/seg_glyph.sv
// Module: renders one slot code as a segment pattern. IS_LEAD selects the
// leading-digit variant, which can show a minus sign and the reduced
// positive-overrange glyph; other digits blank in those cases.
module seg_glyph
    import sevseg_pkg::*;
#(
    parameter bit IS_LEAD = 1'b0
) (
    input  code_t code,
    input  logic  over_neg,
    input  logic  over_pos,
    output seg_t  seg
);
    // Priority: overrange, then sign marker, then decimal table.
    always_comb begin
        if (over_pos)
            seg = IS_LEAD ? SEG_ONLYB : SEG_OFF;
        else if (over_neg)
            seg = IS_LEAD ? SEG_MINUS : SEG_OFF;
        else if (code == CODE_NEG)
            seg = IS_LEAD ? SEG_MINUS : SEG_OFF;
        else
            seg = decimal_glyph(code);
    end
endmodule

// File: rtl/sign_seg7_decoder.sv
// Module: top of the sign-aware seven-segment decoder. Three slot latches
// capture the multiplexed code bus under active-low strobes; a detector
// finds overrange scans; per-digit glyph logic renders the slots. Decimal
// point enables are registered from the select. Assumes all inputs are
// synchronous to clk; reset is synchronous active-low.
module sign_seg7_decoder
    import sevseg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CODE_W-1:0] bcd_code,
    input  logic [NUM_DIG-1:0] dig_strobe_n,
    input  logic              dp_sel,
    output logic [SEG_W-1:0]  seg_msd,
    output logic [SEG_W-1:0]  seg_nsd,
    output logic [SEG_W-1:0]  seg_lsd,
    output logic [DP_W-1:0]   dp_en
);
    localparam int LEAD = NUM_DIG - 1;

    code_t slot_code [NUM_DIG];
    seg_t  slot_seg  [NUM_DIG];
    logic  over_neg, over_pos;

    // One latch and one glyph renderer per digit slot.
    for (genvar i = 0; i < NUM_DIG; i++) begin : g_slot
        seg_slot_latch #(.W(CODE_W), .RST_CODE(CODE_BLANK)) u_latch (
            .clk     (clk),
            .rst_n   (rst_n),
            .strobe_n(dig_strobe_n[i]),
            .code_in (bcd_code),
            .code_q  (slot_code[i])
        );
        seg_glyph #(.IS_LEAD(i == LEAD)) u_glyph (
            .code    (slot_code[i]),
            .over_neg(over_neg),
            .over_pos(over_pos),
            .seg     (slot_seg[i])
        );
    end

    seg_range_detect #(.N(NUM_DIG)) u_range (
        .slot_code(slot_code),
        .over_neg (over_neg),
        .over_pos (over_pos)
    );

    // Map slots to the named digit outputs.
    always_comb begin
        seg_msd = slot_seg[2];
        seg_nsd = slot_seg[1];
        seg_lsd = slot_seg[0];
    end

    // Decimal-point enable register, one-hot after reset.
    always_ff @(posedge clk) begin
        if (!rst_n) dp_en <= '0;
        else        dp_en <= dp_sel ? 2'b10 : 2'b01;
    end

    // R7: negative overrange shows minus on the lead, blanks the rest.
    a_r7_neg_over: assert property (@(posedge clk) disable iff (!rst_n)
        over_neg |-> (seg_msd == SEG_MINUS && seg_nsd == SEG_OFF && seg_lsd == SEG_OFF));

    // R8: positive overrange lights only segment b of the lead digit.
    a_r8_pos_over: assert property (@(posedge clk) disable iff (!rst_n)
        over_pos |-> (seg_msd == SEG_ONLYB && seg_nsd == SEG_OFF && seg_lsd == SEG_OFF));

    // R9: select high lights the second point one edge later.
    a_r9_dp_next: assert property (@(posedge clk) disable iff (!rst_n)
        dp_sel |=> dp_en == 2'b10);

    // R9: select low lights the first point one edge later.
    a_r9_dp_lead: assert property (@(posedge clk) disable iff (!rst_n)
        !dp_sel |=> dp_en == 2'b01);
endmodule

// File: tb/sign_seg7_decoder_bench.sv
// Bench: table-driven scans followed by directed reset, hold, simultaneous
// strobe and decimal-point tests. Inputs change on falling edges; outputs
// are sampled on the falling edge after the edge that should produce them.
module sign_seg7_decoder_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] bcd_code = 4'h0;
    logic [2:0] dig_strobe_n = 3'b111;
    logic       dp_sel = 1'b0;
    logic [6:0] seg_msd, seg_nsd, seg_lsd;
    logic [1:0] dp_en;

    int n_checks = 0;
    int n_fail   = 0;

    always #2.5 clk = ~clk;

    sign_seg7_decoder u_sign_seg7_decoder (
        .clk(clk), .rst_n(rst_n), .bcd_code(bcd_code),
        .dig_strobe_n(dig_strobe_n), .dp_sel(dp_sel),
        .seg_msd(seg_msd), .seg_nsd(seg_nsd), .seg_lsd(seg_lsd), .dp_en(dp_en)
    );

    // Vector: {msd code, nsd code, lsd code, exp msd, exp nsd, exp lsd}
    localparam int NV = 13;
    localparam logic [32:0] VEC [NV] = '{
        {4'h1, 4'h2, 4'h3, 7'h06, 7'h5B, 7'h4F},  // R3
        {4'h4, 4'h5, 4'h6, 7'h66, 7'h6D, 7'h7D},  // R3
        {4'h7, 4'h8, 4'h9, 7'h07, 7'h7F, 7'h6F},  // R3
        {4'h0, 4'h0, 4'h0, 7'h3F, 7'h3F, 7'h3F},  // R3
        {4'hA, 4'h5, 4'h7, 7'h40, 7'h6D, 7'h07},  // R5
        {4'h9, 4'hA, 4'hA, 7'h6F, 7'h00, 7'h00},  // R5
        {4'hA, 4'hA, 4'hA, 7'h40, 7'h00, 7'h00},  // R7
        {4'hB, 4'hB, 4'hB, 7'h02, 7'h00, 7'h00},  // R8
        {4'hB, 4'h1, 4'h2, 7'h00, 7'h06, 7'h5B},  // R6
        {4'hC, 4'hD, 4'hE, 7'h00, 7'h00, 7'h00},  // R6
        {4'hF, 4'hB, 4'hA, 7'h00, 7'h00, 7'h00},  // R6
        {4'hA, 4'hA, 4'hB, 7'h40, 7'h00, 7'h00},  // R5
        {4'hB, 4'hB, 4'hA, 7'h00, 7'h00, 7'h00}   // R6
    };

    task automatic chk(input string req, input logic [6:0] act, input logic [6:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Pulse one slot strobe with a code; returns on the falling edge after capture.
    task automatic load_slot(input int idx, input logic [3:0] c);
        @(negedge clk);
        bcd_code     = c;
        dig_strobe_n = ~(3'b001 << idx);
        @(negedge clk);
        dig_strobe_n = 3'b111;
    endtask

    initial begin
        #(200000 * 5);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        chk("R1 msd", seg_msd, 7'h00);
        chk("R1 nsd", seg_nsd, 7'h00);
        chk("R1 lsd", seg_lsd, 7'h00);
        chk("R1 dp", {5'b0, dp_en}, 7'h00);
        rst_n = 1'b1;

        // Table of scans: MSD, NSD, LSD strobed in turn (R2 latency).
        for (int v = 0; v < NV; v++) begin
            load_slot(2, VEC[v][32:29]);
            load_slot(1, VEC[v][28:25]);
            load_slot(0, VEC[v][24:21]);
            chk($sformatf("R2/R3 vec%0d msd", v), seg_msd, VEC[v][20:14]);
            chk($sformatf("R2/R3 vec%0d nsd", v), seg_nsd, VEC[v][13:7]);
            chk($sformatf("R2/R3 vec%0d lsd", v), seg_lsd, VEC[v][6:0]);
        end

        // R2: capture is due right after the strobed edge.
        load_slot(2, 4'h3);
        chk("R2 single edge msd", seg_msd, 7'h4F);

        // R4: strobes high, bus wiggles, outputs hold.
        load_slot(1, 4'h6);
        load_slot(0, 4'h2);
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            bcd_code = 4'(k + 7);
        end
        @(negedge clk);
        chk("R4 hold msd", seg_msd, 7'h4F);
        chk("R4 hold nsd", seg_nsd, 7'h7D);
        chk("R4 hold lsd", seg_lsd, 7'h5B);

        // R10: all strobes together.
        @(negedge clk);
        bcd_code = 4'h8;
        dig_strobe_n = 3'b000;
        @(negedge clk);
        dig_strobe_n = 3'b111;
        chk("R10 msd", seg_msd, 7'h7F);
        chk("R10 nsd", seg_nsd, 7'h7F);
        chk("R10 lsd", seg_lsd, 7'h7F);

        // R10 + R7: overrange via simultaneous strobe, then leaving it.
        @(negedge clk);
        bcd_code = 4'hA;
        dig_strobe_n = 3'b000;
        @(negedge clk);
        dig_strobe_n = 3'b111;
        chk("R7 msd", seg_msd, 7'h40);
        chk("R7 lsd", seg_lsd, 7'h00);
        load_slot(0, 4'h4);
        chk("R5 exit overrange lsd", seg_lsd, 7'h66);

        // R9: decimal-point select.
        @(negedge clk);
        dp_sel = 1'b0;
        @(negedge clk);
        chk("R9 sel0", {5'b0, dp_en}, 7'h01);
        dp_sel = 1'b1;
        @(negedge clk);
        chk("R9 sel1", {5'b0, dp_en}, 7'h02);

        // R1: reset during operation blanks everything.
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1 mid msd", seg_msd, 7'h00);
        chk("R1 mid nsd", seg_nsd, 7'h00);
        chk("R1 mid dp", {5'b0, dp_en}, 7'h00);
        rst_n = 1'b1;
        @(negedge clk);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule